// File: doc/BRIEF.md
# Isolated Digital I/O Port Controller

This block is a small byte-wide register peripheral that drives sixteen output lines and samples sixteen input lines through an eight-byte register window. The host reaches it through a synchronous bus made of a 3-bit offset, a write strobe with its data byte, and a read strobe. Read data comes back on the clock after the strobe. The sixteen outputs are written as two bytes at separate offsets. The sixteen inputs are read back as two bytes at two other offsets.

Each input passes through a synchroniser. The block then compares each synchronised sample with the one before it. Any difference on any bit sets a single shared pending-interrupt flag, as long as interrupts are armed. There is no per-bit status and no edge selection: rising and falling changes count the same way. Arming and disarming are side effects of bus accesses to one control offset. Reading it arms. Writing it disarms. A write to the low input offset clears the pending flag. The interrupt request pin is the pending flag itself.

Top module: `isoio_ctrl`

## Requirements
- R1: After reset, `dout` is 0x0000, `irq` is 0 and `bus_rdata` is 0x00. Interrupts start disarmed.
- R2: A write to offset 0 loads `dout[7:0]` and a write to offset 4 loads `dout[15:8]`, each on the clock of the strobe. The other output byte keeps its value. Writes to offsets 1, 2, 3, 5, 6 and 7 leave `dout` unchanged.
- R3: A read of offset 1 returns the synchronised `din[7:0]` and a read of offset 5 returns the synchronised `din[15:8]`. The data is on `bus_rdata` one clock after the strobe and holds until the next read strobe.
- R4: A read of offset 0, 2, 3, 4, 6 or 7 returns 0x00.
- R5: A read of offset 2 arms interrupts. A write of any value to offset 2 disarms them.
- R6: While armed, a change in either direction on any `din` bit raises `irq`. The change is applied before a rising clock edge, and `irq` goes high on the (SYNC_STAGES+1)-th rising edge after it.
- R7: Input changes that are fully sampled while disarmed never raise `irq`, including after a later arm.
- R8: Once raised, `irq` stays high until it is cleared. Disarming does not clear it.
- R9: A write of any value to offset 1 clears `irq` on the clock of the strobe. A write to offset 5 does not clear it.
- R10: Arming takes effect on the clock of the read strobe. A change that is detected on that same clock raises `irq`. The same change detected one clock before the strobe does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| din | input | 16 | Asynchronous input lines |
| dout | output | 16 | Output lines |
| irq | output | 1 | Interrupt request (pending flag) |

## Verification
The bench builds the block with the default SYNC_STAGES of 2, so an input change reaches `irq` three edges later. The bench predicts that edge exactly. With this fixed, short latency, the bench can place an arming read so that it lands on the very clock where the change is detected, and then one clock too late. This separates same-clock arming from registered arming. Random sequences of output writes, input changes, arm, disarm and clear accesses are scored against a bench model of the output bytes, the armed state and the pending flag.

// File: rtl/isoio_pkg.sv
// Package: shared constants and offset helpers for the isolated I/O port controller.
// Assumes a byte-wide bus and two 8-bit banks of inputs and outputs.
package isoio_pkg;

    localparam int ADDR_W   = 3;
    localparam int BYTE_W   = 8;
    localparam int NUM_BANK = 2;
    localparam int IO_W     = BYTE_W * NUM_BANK;

    // Control offset: a read arms interrupts, a write disarms them.
    localparam logic [ADDR_W-1:0] CTRL_OFS = 3'd2;

    // Output bank b sits at offset 4*b.
    function automatic logic [ADDR_W-1:0] out_ofs(input int bank);
        return ADDR_W'(4 * bank);
    endfunction

    // Input bank b sits at offset 4*b+1.
    function automatic logic [ADDR_W-1:0] in_ofs(input int bank);
        return ADDR_W'(4 * bank + 1);
    endfunction

    // Decoded bus side effects passed from the register file to the interrupt logic.
    typedef struct packed {
        logic arm;
        logic disarm;
        logic clr;
    } irq_ctl_t;

endpackage

// File: rtl/isoio_sync.sv
// Module: isoio_sync
// Brings asynchronous input lines into the clock domain with a chain of
// STAGES flops per bit. Assumes that each bit is independent: no
// multi-bit coherency is promised across the bus.
module isoio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                // Later stages: shift along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/isoio_chg_irq.sv
// Module: isoio_chg_irq
// Detects any change between consecutive synchronised samples, keeps the
// armed state, and latches one shared pending flag. Assumes the bus never
// strobes arm and disarm in the same cycle; if it does, disarm wins.
// A change detected in the same cycle as a clear keeps the flag set, so
// no event is lost.
module isoio_chg_irq
    import isoio_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp,
    input  irq_ctl_t     ctl,
    output logic         irq
);

    logic [W-1:0] prev_q;
    logic         en_q;
    logic         pend_q;
    logic         chg_any;
    logic         en_now;
    logic         set_now;

    // Change detect: any bit that differs from the previous sample.
    assign chg_any = |(smp ^ prev_q);
    // Arming counts on the strobe's own clock; disarming also.
    assign en_now  = (en_q | ctl.arm) & ~ctl.disarm;
    assign set_now = chg_any & en_now;

    // Previous-sample register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= smp;
    end

    // Armed state: write disarms, read arms.
    always_ff @(posedge clk) begin
        if (!rst_n)          en_q <= 1'b0;
        else if (ctl.disarm) en_q <= 1'b0;
        else if (ctl.arm)    en_q <= 1'b1;
    end

    // Sticky pending flag: a new change wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (set_now) pend_q <= 1'b1;
        else if (ctl.clr) pend_q <= 1'b0;
    end

    assign irq = pend_q;

    AST_PEND_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(en_q || ctl.arm)); // R7
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ctl.clr) |=> pend_q); // R8
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.clr && !chg_any) |=> !pend_q); // R9
    AST_DISARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.disarm |=> !en_q); // R5
    AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.arm && !ctl.disarm) |=> en_q); // R5

endmodule

// File: rtl/isoio_regs.sv
// Module: isoio_regs
// Decodes the byte bus, holds the output bytes, registers read data, and
// turns control accesses into arm, disarm and clear pulses. Assumes the
// read strobe and the write strobe never name the same offset in one
// cycle. Read data holds between read strobes.
module isoio_regs
    import isoio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd,
    input  logic [IO_W-1:0]   in_smp,
    output logic [BYTE_W-1:0] rdata,
    output logic [IO_W-1:0]   out_q,
    output irq_ctl_t          ctl
);

    logic [BYTE_W-1:0] rd_next;
    logic              rd_hit;

    generate
        for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
            // Output byte register for bank b.
            always_ff @(posedge clk) begin
                if (!rst_n)                         out_q[b*BYTE_W +: BYTE_W] <= '0;
                else if (wr && addr == out_ofs(b)) out_q[b*BYTE_W +: BYTE_W] <= wdata;
            end

            AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr && addr == out_ofs(b)) |=> $stable(out_q[b*BYTE_W +: BYTE_W])); // R2
        end
    endgenerate

    // Read mux: input banks return samples, every other offset returns zero.
    always_comb begin
        rd_next = '0;
        rd_hit  = 1'b0;
        for (int b = 0; b < NUM_BANK; b++) begin
            if (addr == in_ofs(b)) begin
                rd_next = in_smp[b*BYTE_W +: BYTE_W];
                rd_hit  = 1'b1;
            end
        end
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_next;
    end

    // Side-effect pulses for the interrupt logic.
    always_comb begin
        ctl.arm    = rd && (addr == CTRL_OFS);
        ctl.disarm = wr && (addr == CTRL_OFS);
        ctl.clr    = wr && (addr == in_ofs(0));
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata)); // R3
    AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !rd_hit) |=> (rdata == '0)); // R4

endmodule

// File: rtl/isoio_ctrl.sv
// Module: isoio_ctrl (top)
// Isolated I/O port controller: sixteen outputs, sixteen synchronised
// inputs, and one change interrupt behind an eight-byte register window.
// Assumes one bus access per cycle and inputs that are asynchronous to clk.
module isoio_ctrl
    import isoio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [IO_W-1:0]   din,
    output logic [IO_W-1:0]   dout,
    output logic              irq
);

    logic [IO_W-1:0] din_sync;
    irq_ctl_t        ctl;

    isoio_sync #(.W(IO_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (din),
        .sync_out (din_sync)
    );

    isoio_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .rd     (bus_rd),
        .in_smp (din_sync),
        .rdata  (bus_rdata),
        .out_q  (dout),
        .ctl    (ctl)
    );

    isoio_chg_irq #(.W(IO_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .smp   (din_sync),
        .ctl   (ctl),
        .irq   (irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (dout == '0 && !irq && bus_rdata == '0)); // R1

endmodule

// File: tb/tb_isoio_ctrl.sv
`timescale 1ns/1ps
module tb_isoio_ctrl;

    localparam int SYNC_STAGES = 2;
    localparam int LAT = SYNC_STAGES + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        irq;

    int total = 0;
    int fails = 0;

    logic [15:0] exp_out = '0;
    logic [15:0] cur_in = '0;
    logic        exp_en = 1'b0;
    logic        exp_pend = 1'b0;

    always #2.5 clk = ~clk;

    isoio_ctrl #(.SYNC_STAGES(SYNC_STAGES)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .din(din), .dout(dout), .irq(irq)
    );

    function automatic logic [7:0] exp_read(input logic [2:0] a, input logic [15:0] v);
        if (a == 3'd1) return v[7:0];
        if (a == 3'd5) return v[15:8];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 3'd0) exp_out[7:0] = d;
        if (a == 3'd4) exp_out[15:8] = d;
        if (a == 3'd2) exp_en = 1'b0;
        if (a == 3'd1) exp_pend = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        if (a == 3'd2) exp_en = 1'b1;
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        din = v;
        repeat (LAT + 1) @(posedge clk);
        @(negedge clk);
        if (v != cur_in && exp_en) exp_pend = 1'b1;
        cur_in = v;
    endtask

    initial begin
        #(5.0 * 100000);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 dout", dout, 16'h0000);
        check("R1 irq", irq, 1'b0);
        check("R1 rdata", bus_rdata, 8'h00);

        // R2 byte writes
        bus_write(3'd0, 8'hA5);
        check("R2 low byte", dout, 16'h00A5);
        bus_write(3'd4, 8'h3C);
        check("R2 high byte", dout, 16'h3CA5);
        bus_write(3'd3, 8'hFF); bus_write(3'd6, 8'hFF);
        bus_write(3'd7, 8'hFF); bus_write(3'd5, 8'hFF);
        check("R2 other offsets ignored", dout, 16'h3CA5);

        // R7 changes while disarmed
        set_pins(16'h1234);
        check("R7 disarmed change", irq, 1'b0);
        bus_read(3'd1, rv);
        check("R3 low input", rv, 8'h34);
        bus_read(3'd5, rv);
        check("R3 high input", rv, 8'h12);
        repeat (3) @(negedge clk);
        check("R3 hold", bus_rdata, 8'h12);
        bus_read(3'd2, rv);
        check("R4 ctrl reads zero", rv, 8'h00);
        repeat (4) @(negedge clk);
        check("R7 no late irq", irq, 1'b0);

        // R6 latency, rising edge on one bit
        @(negedge clk);
        din = 16'h1235;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        check("R6 before latency", irq, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R6 at latency", irq, 1'b1);
        cur_in = 16'h1235; exp_pend = 1'b1;

        // R8 sticky across disarm
        bus_write(3'd2, 8'h00);
        repeat (3) @(negedge clk);
        check("R8 sticky after disarm", irq, 1'b1);
        // R9 write to offset 5 does not clear
        bus_write(3'd5, 8'h00);
        check("R9 offset5 no clear", irq, 1'b1);
        bus_write(3'd1, 8'h5A);
        check("R9 clear", irq, 1'b0);

        // R6 falling edge on high bit
        bus_read(3'd2, rv);
        set_pins(16'h0235);
        check("R6 falling edge", irq, 1'b1);
        bus_write(3'd1, 8'h00);
        bus_write(3'd2, 8'h00);

        // R10 arm on the detection clock
        @(negedge clk);
        din = 16'h0236;
        repeat (SYNC_STAGES) @(posedge clk);
        @(negedge clk);
        bus_addr = 3'd2; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
        check("R10 same-clock arm", irq, 1'b1);
        cur_in = 16'h0236;
        bus_write(3'd1, 8'h00);
        bus_write(3'd2, 8'h00);
        @(negedge clk);
        din = 16'h0237;
        repeat (SYNC_STAGES + 1) @(posedge clk);
        @(negedge clk);
        bus_addr = 3'd2; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
        check("R10 late arm misses", irq, 1'b0);
        cur_in = 16'h0237; exp_en = 1'b1; exp_pend = 1'b0;

        // Randomised mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [2:0] a;
            op = int'($urandom % 7);
            case (op)
                0: bus_write(($urandom % 2) ? 3'd4 : 3'd0, 8'($urandom));
                1: begin
                    a = 3'($urandom);
                    if (a == 3'd0 || a == 3'd4) a = 3'd6;
                    bus_write(a, 8'($urandom));
                end
                2: set_pins(($urandom % 3 == 0) ? cur_in : 16'($urandom));
                3: begin
                    a = 3'($urandom);
                    bus_read(a, rv);
                    if (a == 3'd1 || a == 3'd5) check("R3 random read", rv, exp_read(a, cur_in));
                    else check("R4 random unused read", rv, exp_read(a, cur_in));
                end
                4: bus_read(3'd2, rv);
                5: bus_write(3'd2, 8'($urandom));
                default: bus_write(3'd1, 8'($urandom));
            endcase
            check("R2 random dout", dout, exp_out);
            check("R6 random irq", irq, exp_pend);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule